// File: doc/BRIEF.md
# Display Auxiliary Channel Transaction Controller

This block runs one request/reply transaction at a time on a display auxiliary channel. It carries both native channel traffic and I2C traffic tunnelled over the channel. Software uses a small word-addressed register port. It loads a target address, fills up to sixteen payload bytes into four transmit words, and then writes the control register with a request kind, a length and a go bit. The controller encodes the request into a link command code and issues it on an abstract request interface as a one-cycle pulse.

The reply comes back on an abstract reply interface with a reply code, a byte count, error flags and received data. The controller records these in a status register. A read that is acknowledged with the wrong byte count is refused: the receive words are left untouched and a mismatch flag is raised, so software can retry. An internal watchdog ends a transaction that gets no reply. Completion, hot-plug edges and sink interrupts are latched in an interrupt status register. Each source is masked by its own enable bit before it reaches the interrupt output.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `req_valid_o` are low.
- R2: Request kind codes in CTRL[10:8] are 0 native write, 1 native read, 2 I2C write, 3 I2C read and 4 I2C write-status-update. The middle-of-transaction flag is CTRL[11].
- R2 (continued): The link command is 8 for native write and 9 for native read, whatever the flag. It is 0, 1 or 2 for the three I2C kinds, plus 4 when the flag is set. Kinds 5 to 7 are rejected: the go bit stays 0 and no request is issued.
- R3: The empty flag is CTRL[12]. With the empty flag set, an I2C kind is issued as command 10 (address-only) with length 0. A native kind with the empty flag set is rejected: the go bit stays 0 and no request is issued.
- R4: The length field CTRL[3:0] holds the byte count minus one, so `req_len_o` is that field plus one. `req_addr_o` carries the address register (offset 0). Payload byte k sits in bits 8k+7:8k of `req_data_o`, word i of it comes from offset 8+i, and bytes at or beyond the length read as zero.
- R5: Writing CTRL with bit 16 set starts a transaction. `req_valid_o` is high for exactly the next cycle, and CTRL[16] reads 1 while the transaction runs. The cycle a reply arrives, CTRL[16] clears and interrupt status bit 0 (done) sets.
- R6: If no reply arrives, CTRL[16] clears and both STAT[8] (timeout) and done set exactly TIMEOUT_CYCLES cycles after the request.
- R7: The reply error flags rx, sink and no-stop set STAT[9], STAT[10] and STAT[11], and they are sticky. Writing 1s to STAT[11:8] (the mask 0xF00) clears those flags.
- R8: STAT[19:16] holds the last reply code and STAT[4:0] holds the last reply byte count. The codes are 0 native ACK, 1 native NACK, 2 native DEFER, 4 I2C NACK and 8 I2C DEFER.
- R9: When an acknowledged, error-free, non-empty read returns a count equal to the length, the receive words (offsets 12 to 15) are loaded, with bytes beyond the length zeroed. On a count mismatch the receive words are kept and STAT[12] sets. STAT[12] clears when the next transaction starts.
- R10: Interrupt status (offset 4) holds bit 0 done, bit 1 plug, bit 2 unplug and bit 3 sink IRQ. Each bit is write-1-to-clear. `irq_o` is high only while some status bit and its enable bit (offset 3) are both set.
- R11: STAT[28] shows `hpd_i` one cycle late. A rising edge sets plug, a falling edge sets unplug, and a `sink_irq_i` pulse sets the sink IRQ bit.
- R12: While a transaction runs, writes to the address, control and transmit registers are ignored. A reply that arrives while idle changes no state.
- R13: Offsets 5, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Register access strobe |
| cpu_we_i | input | 1 | Write enable for the access |
| cpu_addr_i | input | 4 | Register word offset |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Read data for `cpu_addr_i` (combinational) |
| irq_o | output | 1 | Masked interrupt |
| hpd_i | input | 1 | Hot-plug level, already debounced |
| sink_irq_i | input | 1 | Sink interrupt event pulse |
| req_valid_o | output | 1 | One-cycle request pulse |
| req_cmd_o | output | 4 | Link command code |
| req_addr_o | output | 20 | Target address |
| req_len_o | output | 5 | Byte count, 0 to 16 |
| req_data_o | output | 128 | Payload, byte k at bits 8k+7:8k |
| rsp_valid_i | input | 1 | Reply strobe |
| rsp_code_i | input | 4 | Reply code |
| rsp_count_i | input | 5 | Bytes returned |
| rsp_err_i | input | 3 | Error flags: rx, sink, no-stop |
| rsp_data_i | input | 128 | Returned bytes |

## Verification
The assertions check the following on every cycle:
- the request pulse lasts a single cycle and is raised only while a transaction is open;
- every issued command is one of the legal codes;
- an empty request always leaves as the address-only command;
- a reply always closes the transaction and raises done;
- the address register holds while a transaction runs;
- the unused offsets read zero.

The exact command mapping, the payload masking and the receive-word update are value-dependent, so only the bench scenarios can show them. The same holds for the refusal of mismatched reads, the timeout instant, the clearing of the sticky errors and the interrupt gating.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
  localparam int OFF_ADDR  = 0;
  localparam int OFF_CTRL  = 1;
  localparam int OFF_STAT  = 2;
  localparam int OFF_IEN   = 3;
  localparam int OFF_ISTAT = 4;
  localparam int TX_BASE   = 8;

  localparam int CTRL_KIND  = 8;
  localparam int CTRL_MOT   = 11;
  localparam int CTRL_EMPTY = 12;
  localparam int CTRL_GO    = 16;

  localparam int STAT_ERR   = 8;
  localparam int STAT_MIS   = 12;
  localparam int STAT_RTYPE = 16;
  localparam int STAT_HPD   = 28;

  typedef enum logic [2:0] {
    K_NAT_WR  = 3'd0,
    K_NAT_RD  = 3'd1,
    K_I2C_WR  = 3'd2,
    K_I2C_RD  = 3'd3,
    K_I2C_WSU = 3'd4
  } req_kind_e;

  localparam logic [3:0] CMD_I2C_WR  = 4'h0;
  localparam logic [3:0] CMD_I2C_RD  = 4'h1;
  localparam logic [3:0] CMD_I2C_WSU = 4'h2;
  localparam logic [3:0] CMD_MOT_BIT = 4'h4;
  localparam logic [3:0] CMD_NAT_WR  = 4'h8;
  localparam logic [3:0] CMD_NAT_RD  = 4'h9;
  localparam logic [3:0] CMD_ADDR_ONLY = 4'hA;

  localparam logic [3:0] RPL_ACK = 4'h0;
endpackage

// File: rtl/aux_cmd_enc.sv
module aux_cmd_enc
  import aux_xact_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       mot_i,
  input  logic       empty_i,
  output logic [3:0] cmd_o,
  output logic       legal_o,
  output logic       is_read_o
);
  logic [3:0] i2c_base;
  logic       is_i2c;

  always_comb begin
    i2c_base  = CMD_I2C_WR;
    is_i2c    = 1'b0;
    legal_o   = 1'b1;
    is_read_o = 1'b0;
    cmd_o     = CMD_NAT_WR;
    case (kind_i)
      K_NAT_WR:  cmd_o = CMD_NAT_WR;
      K_NAT_RD:  begin cmd_o = CMD_NAT_RD; is_read_o = 1'b1; end
      K_I2C_WR:  begin is_i2c = 1'b1; i2c_base = CMD_I2C_WR; end
      K_I2C_RD:  begin is_i2c = 1'b1; i2c_base = CMD_I2C_RD; is_read_o = 1'b1; end
      K_I2C_WSU: begin is_i2c = 1'b1; i2c_base = CMD_I2C_WSU; end
      default:   legal_o = 1'b0;
    endcase
    if (is_i2c) cmd_o = i2c_base | (mot_i ? CMD_MOT_BIT : 4'h0);
    // empty requests: address-only for I2C, refused for native
    if (empty_i) begin
      if (is_i2c) cmd_o = CMD_ADDR_ONLY;
      else        legal_o = 1'b0;
    end
  end
endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
  parameter  int TIMEOUT_CYCLES = 1024,
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rsp_valid_i,
  output logic busy_o,
  output logic req_valid_o,
  output logic accept_o,
  output logic timeout_o
);
  logic [CNT_W-1:0] cnt_q;

  assign accept_o  = busy_o & rsp_valid_i;
  assign timeout_o = busy_o & ~rsp_valid_i & (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      req_valid_o <= 1'b0;
      cnt_q       <= '0;
    end else begin
      req_valid_o <= start_i;
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (accept_o || timeout_o) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_irq_unit.sv
module aux_irq_unit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hpd_i,
  input  logic       sink_irq_i,
  input  logic       done_i,
  input  logic       wr_en_i,
  input  logic       wr_stat_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] en_o,
  output logic [3:0] stat_o,
  output logic       hpd_o,
  output logic       irq_o
);
  logic [3:0] ev;
  logic [3:0] clr;

  assign ev    = {sink_irq_i, ~hpd_i & hpd_o, hpd_i & ~hpd_o, done_i};
  assign clr   = wr_stat_i ? wdata_i : 4'h0;
  assign irq_o = |(stat_o & en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      stat_o <= '0;
      hpd_o  <= 1'b0;
    end else begin
      hpd_o  <= hpd_i;
      stat_o <= (stat_o & ~clr) | ev;  // a new event wins over a clear
      if (wr_en_i) en_o <= wdata_i;
    end
  end
endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
  import aux_xact_pkg::*;
#(
  parameter  int NUM_WORDS      = 4,
  parameter  int ADDR_W         = 20,
  parameter  int TIMEOUT_CYCLES = 1024,
  localparam int BYTES   = NUM_WORDS * 4,
  localparam int BUF_W   = BYTES * 8,
  localparam int LEN_W   = $clog2(BYTES + 1),
  localparam int LM1_W   = $clog2(BYTES),
  localparam int RX_BASE = TX_BASE + NUM_WORDS,
  localparam int OFF_W   = $clog2(RX_BASE + NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [OFF_W-1:0]  cpu_addr_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  output logic              irq_o,
  input  logic              hpd_i,
  input  logic              sink_irq_i,
  output logic              req_valid_o,
  output logic [3:0]        req_cmd_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [BUF_W-1:0]  req_data_o,
  input  logic              rsp_valid_i,
  input  logic [3:0]        rsp_code_i,
  input  logic [LEN_W-1:0]  rsp_count_i,
  input  logic [2:0]        rsp_err_i,
  input  logic [BUF_W-1:0]  rsp_data_i
);
  logic wr, wr_addr, wr_ctrl, wr_stat, wr_ien, wr_istat;
  logic busy, start, accept, tmo, done;
  logic legal_wr, is_read;
  logic unused_cmd_wr, unused_rd_wr, unused_legal_q;
  logic [3:0] cmd_wr_full;

  logic [ADDR_W-1:0] addr_q;
  logic [LM1_W-1:0]  lm1_q;
  logic [2:0]        kind_q;
  logic              mot_q, empty_q;

  logic [3:0]        err_q;
  logic              mis_q;
  logic [3:0]        rtype_q;
  logic [LEN_W-1:0]  rcnt_q;

  logic [3:0]        int_en, int_stat;
  logic              hpd_q;

  logic [31:0]       tx_q [NUM_WORDS];
  logic [31:0]       rx_q [NUM_WORDS];
  logic [BYTES-1:0]  byte_en;
  logic [BUF_W-1:0]  byte_mask;
  logic              is_ack, rx_load, mis_set;

  assign wr       = cpu_req_i & cpu_we_i;
  assign wr_addr  = wr && (cpu_addr_i == OFF_W'(OFF_ADDR));
  assign wr_ctrl  = wr && (cpu_addr_i == OFF_W'(OFF_CTRL));
  assign wr_stat  = wr && (cpu_addr_i == OFF_W'(OFF_STAT));
  assign wr_ien   = wr && (cpu_addr_i == OFF_W'(OFF_IEN));
  assign wr_istat = wr && (cpu_addr_i == OFF_W'(OFF_ISTAT));

  // legality of the incoming control word
  aux_cmd_enc u_enc_wr (
    .kind_i    (cpu_wdata_i[CTRL_KIND +: 3]),
    .mot_i     (cpu_wdata_i[CTRL_MOT]),
    .empty_i   (cpu_wdata_i[CTRL_EMPTY]),
    .cmd_o     (cmd_wr_full),
    .legal_o   (legal_wr),
    .is_read_o (unused_rd_wr)
  );
  assign unused_cmd_wr = ^cmd_wr_full;

  // command for the held request
  aux_cmd_enc u_enc_q (
    .kind_i    (kind_q),
    .mot_i     (mot_q),
    .empty_i   (empty_q),
    .cmd_o     (req_cmd_o),
    .legal_o   (unused_legal_q),
    .is_read_o (is_read)
  );

  assign start = wr_ctrl & ~busy & cpu_wdata_i[CTRL_GO] & legal_wr;

  aux_xact_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .rsp_valid_i (rsp_valid_i),
    .busy_o      (busy),
    .req_valid_o (req_valid_o),
    .accept_o    (accept),
    .timeout_o   (tmo)
  );

  assign done = accept | tmo;

  aux_irq_unit u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hpd_i      (hpd_i),
    .sink_irq_i (sink_irq_i),
    .done_i     (done),
    .wr_en_i    (wr_ien),
    .wr_stat_i  (wr_istat),
    .wdata_i    (cpu_wdata_i[3:0]),
    .en_o       (int_en),
    .stat_o     (int_stat),
    .hpd_o      (hpd_q),
    .irq_o      (irq_o)
  );

  assign req_addr_o = addr_q;
  assign req_len_o  = empty_q ? '0 : LEN_W'(lm1_q) + LEN_W'(1);

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign byte_en[b]         = (LEN_W'(b) < req_len_o);
    assign byte_mask[8*b +: 8] = {8{byte_en[b]}};
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_tx
    assign req_data_o[32*w +: 32] = tx_q[w] & byte_mask[32*w +: 32];
  end

  assign is_ack  = (rsp_code_i == RPL_ACK);
  assign rx_load = accept & is_ack & is_read & ~empty_q & (rsp_count_i == req_len_o) & (rsp_err_i == '0);
  assign mis_set = accept & is_ack & is_read & ~empty_q & (rsp_count_i != req_len_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      lm1_q   <= '0;
      kind_q  <= '0;
      mot_q   <= 1'b0;
      empty_q <= 1'b0;
    end else if (!busy) begin
      if (wr_addr) addr_q <= cpu_wdata_i[ADDR_W-1:0];
      if (wr_ctrl) begin
        lm1_q   <= cpu_wdata_i[LM1_W-1:0];
        kind_q  <= cpu_wdata_i[CTRL_KIND +: 3];
        mot_q   <= cpu_wdata_i[CTRL_MOT];
        empty_q <= cpu_wdata_i[CTRL_EMPTY];
      end
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q[w] <= '0;
        rx_q[w] <= '0;
      end else begin
        if (!busy && wr && cpu_addr_i == OFF_W'(TX_BASE + w)) tx_q[w] <= cpu_wdata_i;
        if (rx_load) rx_q[w] <= rsp_data_i[32*w +: 32] & byte_mask[32*w +: 32];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      mis_q   <= 1'b0;
      rtype_q <= '0;
      rcnt_q  <= '0;
    end else begin
      err_q <= (err_q & ~(wr_stat ? cpu_wdata_i[STAT_ERR +: 4] : 4'h0))
             | {accept ? rsp_err_i : 3'b000, tmo};
      if (start)        mis_q <= 1'b0;
      else if (mis_set) mis_q <= 1'b1;
      if (accept) begin
        rtype_q <= rsp_code_i;
        rcnt_q  <= rsp_count_i;
      end
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    case (cpu_addr_i)
      OFF_W'(OFF_ADDR): cpu_rdata_o[ADDR_W-1:0] = addr_q;
      OFF_W'(OFF_CTRL): begin
        cpu_rdata_o[LM1_W-1:0]        = lm1_q;
        cpu_rdata_o[CTRL_KIND +: 3]   = kind_q;
        cpu_rdata_o[CTRL_MOT]         = mot_q;
        cpu_rdata_o[CTRL_EMPTY]       = empty_q;
        cpu_rdata_o[CTRL_GO]          = busy;
      end
      OFF_W'(OFF_STAT): begin
        cpu_rdata_o[LEN_W-1:0]        = rcnt_q;
        cpu_rdata_o[STAT_ERR +: 4]    = err_q;
        cpu_rdata_o[STAT_MIS]         = mis_q;
        cpu_rdata_o[STAT_RTYPE +: 4]  = rtype_q;
        cpu_rdata_o[STAT_HPD]         = hpd_q;
      end
      OFF_W'(OFF_IEN):   cpu_rdata_o[3:0] = int_en;
      OFF_W'(OFF_ISTAT): cpu_rdata_o[3:0] = int_stat;
      default: begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (cpu_addr_i == OFF_W'(TX_BASE + w)) cpu_rdata_o = tx_q[w];
          if (cpu_addr_i == OFF_W'(RX_BASE + w)) cpu_rdata_o = rx_q[w];
        end
      end
    endcase
  end
endmodule

// File: rtl/aux_xact_ctrl_chk.sv
module aux_xact_ctrl_chk #(
  parameter int BYTES  = 16,
  parameter int OFF_W  = 4,
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              req_valid_i,
  input logic [3:0]        req_cmd_i,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              rsp_valid_i,
  input logic [3:0]        int_stat_i,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [OFF_W-1:0]  cpu_addr_i,
  input logic [31:0]       cpu_rdata_i,
  input logic [ADDR_W-1:0] addr_q_i
);
  assert_req_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !req_valid_i);

  assert_req_in_xact_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> busy_i);

  assert_reply_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rsp_valid_i) |=> (!busy_i && int_stat_i[0]));

  assert_cmd_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_cmd_i inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA}));

  assert_empty_addr_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_len_i == '0) |-> req_cmd_i == 4'hA);

  assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_len_i <= LEN_W'(BYTES)));

  assert_addr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cpu_req_i && cpu_we_i && cpu_addr_i == '0) |=> $stable(addr_q_i));

  assert_unmapped_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i inside {OFF_W'(5), OFF_W'(6), OFF_W'(7)}) |-> cpu_rdata_i == '0);
endmodule

bind aux_xact_ctrl aux_xact_ctrl_chk #(
  .BYTES(BYTES), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy),
  .req_valid_i (req_valid_o),
  .req_cmd_i   (req_cmd_o),
  .req_len_i   (req_len_o),
  .rsp_valid_i (rsp_valid_i),
  .int_stat_i  (int_stat),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_rdata_i (cpu_rdata_o),
  .addr_q_i    (addr_q)
);

// File: tb/aux_xact_ctrl_tb.sv
`timescale 1ns/1ps
module aux_xact_ctrl_tb;
  localparam int TMO = 40;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [3:0]   cpu_addr_i = '0;
  logic [31:0]  cpu_wdata_i = '0;
  logic [31:0]  cpu_rdata_o;
  logic         irq_o;
  logic         hpd_i = 1'b0, sink_irq_i = 1'b0;
  logic         req_valid_o;
  logic [3:0]   req_cmd_o;
  logic [19:0]  req_addr_o;
  logic [4:0]   req_len_o;
  logic [127:0] req_data_o;
  logic         rsp_valid_i = 1'b0;
  logic [3:0]   rsp_code_i = '0;
  logic [4:0]   rsp_count_i = '0;
  logic [2:0]   rsp_err_i = '0;
  logic [127:0] rsp_data_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [3:0]   cap_cmd;
  logic [4:0]   cap_len;
  logic [127:0] cap_data;
  logic [19:0]  cap_addr;

  always #4 clk = ~clk;

  aux_xact_ctrl #(.TIMEOUT_CYCLES(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .irq_o(irq_o),
    .hpd_i(hpd_i), .sink_irq_i(sink_irq_i),
    .req_valid_o(req_valid_o), .req_cmd_o(req_cmd_o), .req_addr_o(req_addr_o),
    .req_len_o(req_len_o), .req_data_o(req_data_o),
    .rsp_valid_i(rsp_valid_i), .rsp_code_i(rsp_code_i), .rsp_count_i(rsp_count_i),
    .rsp_err_i(rsp_err_i), .rsp_data_i(rsp_data_i)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int off, input logic [31:0] d);
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = 4'(off); cpu_wdata_i = d;
    @(posedge clk); #1;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  task automatic rd_reg(input int off, output logic [31:0] d);
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = 4'(off);
    #1 d = cpu_rdata_o;
    cpu_req_i = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int kind, input bit mot, input bit empty,
                                     input int lm1, input bit go);
    return (32'(go) << 16) | (32'(empty) << 12) | (32'(mot) << 11) |
           (32'(kind) << 8) | 32'(lm1);
  endfunction

  task automatic start(input logic [31:0] ctrl, input bit exp_req, input string tag);
    wr_reg(1, ctrl);
    chk(tag, {127'b0, req_valid_o}, {127'b0, exp_req});
    cap_cmd = req_cmd_o; cap_len = req_len_o; cap_data = req_data_o; cap_addr = req_addr_o;
  endtask

  task automatic reply(input logic [3:0] code, input logic [4:0] cnt,
                       input logic [2:0] err, input logic [127:0] data);
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_code_i = code; rsp_count_i = cnt; rsp_err_i = err; rsp_data_i = data;
    @(posedge clk); #1;
    rsp_valid_i = 1'b0;
  endtask

  function automatic logic [127:0] pattern(input logic [7:0] base);
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[8*k +: 8] = base + 8'(k);
    return p;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int off = 0; off < 16; off++) begin
      rd_reg(off, d);
      chk($sformatf("R1 reg %0d after reset", off), d, 0);
    end
    chk("R1 irq after reset", irq_o, 0);
    chk("R1 req_valid after reset", req_valid_o, 0);
  endtask

  task automatic t_native_write();
    logic [31:0] d;
    wr_reg(0, 32'h12345);
    wr_reg(8, 32'h44332211);
    wr_reg(9, 32'h88776655);
    wr_reg(10, 32'hCCBBAA99);
    wr_reg(11, 32'h00FFEEDD);
    start(mk(0, 0, 0, 5, 1), 1, "R5 request pulse after go");
    chk("R2 native write cmd", cap_cmd, 4'h8);
    chk("R4 length is field plus one", cap_len, 5'd6);
    chk("R4 request address", cap_addr, 20'h12345);
    chk("R4 payload byte order and masking", cap_data, {80'h0, 48'h665544332211});
    @(posedge clk); #1;
    chk("R5 pulse lasts one cycle", req_valid_o, 0);
    rd_reg(1, d);
    chk("R5 go reads 1 while open", d[16], 1);
    reply(4'h0, 5'd0, 3'b000, '0);
    rd_reg(1, d);
    chk("R5 go self-clears on reply", d[16], 0);
    rd_reg(4, d);
    chk("R5 done interrupt set", d[0], 1);
    rd_reg(2, d);
    chk("R8 reply type ack", d[19:16], 4'h0);
  endtask

  task automatic t_encode();
    logic [31:0] d;
    logic [3:0] exp;
    for (int k = 0; k < 5; k++) begin
      for (int m = 0; m < 2; m++) begin
        case (k)
          0: exp = 4'h8;
          1: exp = 4'h9;
          2: exp = m ? 4'h4 : 4'h0;
          3: exp = m ? 4'h5 : 4'h1;
          default: exp = m ? 4'h6 : 4'h2;
        endcase
        start(mk(k, m[0], 0, 0, 1), 1, "R2 request issued");
        chk($sformatf("R2 cmd kind %0d mot %0d", k, m), cap_cmd, exp);
        reply(4'h0, 5'd1, 3'b000, '0);
      end
    end
    start(mk(5, 0, 0, 0, 1), 0, "R2 reserved kind rejected");
    rd_reg(1, d);
    chk("R2 reserved kind go stays 0", d[16], 0);
  endtask

  task automatic t_zero_len();
    logic [31:0] d;
    start(mk(3, 1, 1, 0, 1), 1, "R3 empty I2C issued");
    chk("R3 address-only cmd", cap_cmd, 4'hA);
    chk("R3 address-only length", cap_len, 0);
    reply(4'h0, 5'd0, 3'b000, '0);
    start(mk(0, 0, 1, 0, 1), 0, "R3 empty native write rejected");
    rd_reg(1, d);
    chk("R3 rejected go stays 0", d[16], 0);
    start(mk(1, 0, 1, 0, 1), 0, "R3 empty native read rejected");
  endtask

  task automatic t_read_match();
    logic [31:0] d;
    start(mk(3, 0, 0, 6, 1), 1, "R9 read issued");
    reply(4'h0, 5'd7, 3'b000, pattern(8'hA0));
    rd_reg(12, d); chk("R9 rx word0", d, 32'hA3A2A1A0);
    rd_reg(13, d); chk("R9 rx word1 partial", d, 32'h00A6A5A4);
    rd_reg(14, d); chk("R9 rx word2 zero", d, 0);
    rd_reg(2, d);
    chk("R8 rx count", d[4:0], 5'd7);
    chk("R9 no mismatch", d[12], 0);
  endtask

  task automatic t_read_mismatch();
    logic [31:0] d;
    start(mk(1, 0, 0, 3, 1), 1, "R9 read issued");
    reply(4'h0, 5'd3, 3'b000, pattern(8'h10));
    rd_reg(12, d); chk("R9 rx kept on mismatch", d, 32'hA3A2A1A0);
    rd_reg(2, d);
    chk("R9 mismatch flag", d[12], 1);
    chk("R8 count on mismatch", d[4:0], 5'd3);
    start(mk(0, 0, 0, 0, 1), 1, "R9 next start");
    rd_reg(2, d);
    chk("R9 mismatch cleared at start", d[12], 0);
    reply(4'h0, 5'd0, 3'b000, '0);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    start(mk(2, 0, 0, 1, 1), 1, "R7 issued");
    reply(4'h1, 5'd0, 3'b101, '0);
    rd_reg(2, d);
    chk("R7 error flags set", d & 32'h000F1F00, 32'h00010A00);
    start(mk(2, 0, 0, 1, 1), 1, "R7 issued again");
    reply(4'h2, 5'd0, 3'b000, '0);
    rd_reg(2, d);
    chk("R7 flags sticky", d[11:8], 4'hA);
    chk("R8 reply type defer", d[19:16], 4'h2);
    wr_reg(2, 32'h00000F00);
    rd_reg(2, d);
    chk("R7 flags cleared by 0xF00", d[12:8], 0);
    chk("R8 type kept after clear", d[19:16], 4'h2);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr_reg(4, 32'hF);
    start(mk(0, 0, 0, 0, 1), 1, "R6 issued");
    repeat (TMO - 2) @(posedge clk);
    #1;
    rd_reg(1, d);
    chk("R6 still open before timeout", d[16], 1);
    repeat (3) @(posedge clk);
    #1;
    rd_reg(1, d);
    chk("R6 go cleared by timeout", d[16], 0);
    rd_reg(2, d);
    chk("R6 timeout flag", d[8], 1);
    rd_reg(4, d);
    chk("R6 done on timeout", d[0], 1);
    wr_reg(2, 32'h00000F00);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr_reg(4, 32'hF);
    wr_reg(3, 32'h0);
    start(mk(0, 0, 0, 0, 1), 1, "R10 issued");
    reply(4'h0, 5'd0, 3'b000, '0);
    chk("R10 masked irq low", irq_o, 0);
    wr_reg(3, 32'h1);
    chk("R10 enabled irq high", irq_o, 1);
    wr_reg(4, 32'h1);
    chk("R10 w1c drops irq", irq_o, 0);
    rd_reg(4, d);
    chk("R10 done cleared", d[3:0], 0);
    @(negedge clk) hpd_i = 1'b1;
    @(posedge clk); #1;
    rd_reg(2, d);
    chk("R11 hpd status", d[28], 1);
    rd_reg(4, d);
    chk("R11 plug event", d[3:0], 4'h2);
    chk("R10 plug not enabled no irq", irq_o, 0);
    @(negedge clk) hpd_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk) sink_irq_i = 1'b1;
    @(posedge clk); #1 sink_irq_i = 1'b0;
    rd_reg(4, d);
    chk("R11 unplug and sink events", d[3:0], 4'hE);
    rd_reg(2, d);
    chk("R11 hpd low", d[28], 0);
    wr_reg(4, 32'hF);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    wr_reg(0, 32'h00ABC);
    start(mk(0, 0, 0, 0, 1), 1, "R12 issued");
    wr_reg(0, 32'h11111);
    rd_reg(0, d);
    chk("R12 address held while open", d, 32'h00ABC);
    wr_reg(1, mk(1, 0, 0, 5, 0));
    rd_reg(1, d);
    chk("R12 control held while open", d, 32'h00010000);
    wr_reg(8, 32'hDEADBEEF);
    rd_reg(8, d);
    chk("R12 tx held while open", d, 32'h44332211);
    reply(4'h0, 5'd0, 3'b000, '0);
    wr_reg(4, 32'hF);
    reply(4'h2, 5'd9, 3'b111, '0);
    rd_reg(2, d);
    chk("R12 idle reply ignored", d & 32'h000F1F1F, 0);
    rd_reg(4, d);
    chk("R12 idle reply no done", d[3:0], 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    for (int off = 5; off < 8; off++) begin
      rd_reg(off, d);
      chk($sformatf("R13 offset %0d reads zero", off), d, 0);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_native_write();
    t_encode();
    t_zero_len();
    t_read_match();
    t_read_mismatch();
    t_errors();
    t_timeout();
    t_irq();
    t_busy_ignore();
    t_unmapped();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end
endmodule